// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level table of 4 KiB pages. The walk starts at a page-directory base held in a root register. The top ten address bits select a directory entry. That entry names the frame of a page table, and the next ten bits select a table entry inside it. The table entry names the 4 KiB physical frame, and the low twelve bits are carried over unchanged.

Each request gives the access kind (read or write) and the privilege level (user or supervisor). The walker reads both entries through a word-wide memory port that uses a request/acknowledge handshake. It checks the present, writable and user bits at both levels.

On success it sets the accessed flag in every entry it used. On a write it also sets the dirty flag in the table entry. Each flag update is done as a read-modify-write. The walker then answers with either a physical address or a fault that carries a cause code. A fault leaves memory untouched.

Top module: `pgwalk_top`

## Requirements
- R1: The directory entry is read at {root_base[31:12], req_vaddr[31:22], 2'b00} and the table entry at {directory entry[31:12], req_vaddr[21:12], 2'b00}. A successful response gives rsp_paddr = {table entry[31:12], req_vaddr[11:0]}.
- R2: An entry with bit 0 (present) clear ends the walk with rsp_cause 2'b01. A non-present directory entry ends the walk after that single read, with no table read.
- R3: A write access through an entry that has bit 1 (writable) clear, at either level, faults with rsp_cause 2'b10. Supervisor writes get no exemption.
- R4: A user access through an entry that has bit 2 (user) clear, at either level, faults with rsp_cause 2'b11. Supervisor accesses ignore bit 2. Within an entry, not-present is reported first, then privilege, then write-protect. The directory entry is judged before the table entry.
- R5: After a successful walk, bit 5 (accessed) is set in both entries. An entry is written only if one of its flags must change, and it gets exactly one write.
- R6: A successful write access sets bit 6 (dirty) in the table entry. A read never sets bit 6, and the directory entry's bit 6 is never changed.
- R7: A faulting walk performs no memory write.
- R8: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R9: rsp_valid is a one-cycle pulse, sent only after every flag write is acknowledged. rsp_fault is 1 exactly when rsp_cause is not 2'b00, and a success carries cause 2'b00. req_ready is high only when no walk is in progress.
- R10: Two directory entries that point to the same page table each translate correctly. Only the directory entry actually used gets its accessed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| root_base | input | 32 | Page-directory base; bits [31:12] used |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of entry (byte address, 4-aligned) |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 none, 01 not present, 10 write-protect, 11 privilege |
| rsp_paddr | output | 32 | Physical address on success, zero on fault |

## Verification
An entry latched from the wrong read, or a state skipped, shows up in that walk's own response. It appears as a bad frame in rsp_paddr, a cause from the wrong level, or an extra or missing write seen on the memory port. The bench counts reads and writes on every walk and inspects memory afterwards. A flag merged wrongly therefore shows up as soon as the next walk reads that entry. It is also caught directly in the memory image.

// File: rtl/pw_pkg.sv
package pw_pkg;

    // Entry bit positions (decoded by software that builds the tables)
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER     = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY    = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB_DIR,
        ST_WB_TBL,
        ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_NP   = 2'b01,
        CAUSE_WP   = 2'b10,
        CAUSE_PRIV = 2'b11
    } cause_e;

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int SLOT_W = IDX_W + 2;

    logic [SLOT_W-1:0] slot_off;

    always_comb begin
        slot_off   = {index, 2'b00};
        entry_addr = {base_frame, {OFF_W{1'b0}}} | ADDR_W'(slot_off);
    end

    initial begin
        assert (SLOT_W <= OFF_W) else $error("index slots exceed one page");
    end
endmodule

// File: rtl/pw_perm_chk.sv
module pw_perm_chk #(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    output logic             fault,
    output pw_pkg::cause_e   cause
);
    import pw_pkg::*;

    always_comb begin
        fault = 1'b1;
        cause = CAUSE_NONE;
        if (!entry[BIT_PRESENT]) begin
            cause = CAUSE_NP;
        end else if (is_user && !entry[BIT_USER]) begin
            cause = CAUSE_PRIV;
        end else if (is_write && !entry[BIT_WRITABLE]) begin
            cause = CAUSE_WP;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/pw_flag_merge.sv
module pw_flag_merge #(
    parameter int ENT_W    = 32,
    parameter bit IS_TABLE = 1'b0
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    output logic             need_wb,
    output logic [ENT_W-1:0] new_entry
);
    import pw_pkg::*;

    logic want_dirty;

    generate
        if (IS_TABLE) begin : g_leaf
            assign want_dirty = is_write & ~entry[BIT_DIRTY];
        end else begin : g_node
            assign want_dirty = 1'b0;
        end
    endgenerate

    always_comb begin
        new_entry               = entry;
        new_entry[BIT_ACCESSED] = 1'b1;
        if (want_dirty) begin
            new_entry[BIT_DIRTY] = 1'b1;
        end
        need_wb = ~entry[BIT_ACCESSED] | want_dirty;
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_paddr
);
    import pw_pkg::*;

    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int IDX_W   = FRAME_W / 2;
    localparam int TBL_LO  = OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic              wr;
        logic              usr;
        logic [ADDR_W-1:0] pde;
        logic [ADDR_W-1:0] pte;
        logic              fault;
        cause_e            cause;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;
    logic              chk_fault;
    cause_e            chk_cause;
    logic              dir_need_wb;
    logic [ADDR_W-1:0] dir_new;
    logic              tbl_need_wb;
    logic [ADDR_W-1:0] tbl_new;
    logic [ADDR_W-1:0] tbl_src;

    // Directory slot address from the root frame
    pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
        .base_frame (root_base[ADDR_W-1:OFF_W]),
        .index      (q.va[DIR_LO +: IDX_W]),
        .entry_addr (dir_addr)
    );

    // Table slot address from the latched directory entry
    pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
        .base_frame (q.pde[ADDR_W-1:OFF_W]),
        .index      (q.va[TBL_LO +: IDX_W]),
        .entry_addr (tbl_addr)
    );

    // One checker serves both levels: it judges whatever entry is arriving
    pw_perm_chk #(.ENT_W(ADDR_W)) u_chk (
        .entry    (mem_rdata),
        .is_write (q.wr),
        .is_user  (q.usr),
        .fault    (chk_fault),
        .cause    (chk_cause)
    );

    pw_flag_merge #(.ENT_W(ADDR_W), .IS_TABLE(1'b0)) u_dir_flags (
        .entry     (q.pde),
        .is_write  (q.wr),
        .need_wb   (dir_need_wb),
        .new_entry (dir_new)
    );

    assign tbl_src = (q.st == ST_RD_TBL) ? mem_rdata : q.pte;

    pw_flag_merge #(.ENT_W(ADDR_W), .IS_TABLE(1'b1)) u_tbl_flags (
        .entry     (tbl_src),
        .is_write  (q.wr),
        .need_wb   (tbl_need_wb),
        .new_entry (tbl_new)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.fault = 1'b0;
                    d.cause = CAUSE_NONE;
                    d.st    = ST_RD_DIR;
                end
            end
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) begin
                    d.pde = mem_rdata;
                    if (chk_fault) begin
                        d.fault = 1'b1;
                        d.cause = chk_cause;
                        d.st    = ST_RESP;
                    end else begin
                        d.st = ST_RD_TBL;
                    end
                end
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    d.pte = mem_rdata;
                    if (chk_fault) begin
                        d.fault = 1'b1;
                        d.cause = chk_cause;
                        d.st    = ST_RESP;
                    end else if (dir_need_wb) begin
                        d.st = ST_WB_DIR;
                    end else if (tbl_need_wb) begin
                        d.st = ST_WB_TBL;
                    end else begin
                        d.st = ST_RESP;
                    end
                end
            end
            ST_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_new;
                if (mem_ack) begin
                    d.st = tbl_need_wb ? ST_WB_TBL : ST_RESP;
                end
            end
            ST_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = tbl_new;
                if (mem_ack) begin
                    d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.va    <= '0;
            q.wr    <= 1'b0;
            q.usr   <= 1'b0;
            q.pde   <= '0;
            q.pte   <= '0;
            q.fault <= 1'b0;
            q.cause <= CAUSE_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = (q.st == ST_RESP);
    assign rsp_fault = q.fault;
    assign rsp_cause = q.cause;
    assign rsp_paddr = q.fault ? '0 : {q.pte[ADDR_W-1:OFF_W], q.va[OFF_W-1:0]};

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))) else $error("request dropped or changed before ack"); // R8

    AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACCESSED]) else $error("write-back without accessed flag"); // R5

    AST_DIR_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WB_DIR && mem_we) |-> (mem_wdata[BIT_DIRTY] == q.pde[BIT_DIRTY])) else $error("directory dirty flag altered"); // R6

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !$past(mem_we)) else $error("fault preceded by a write"); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R9

    AST_CAUSE_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00))) else $error("fault flag and cause disagree"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req) else $error("memory access while idle"); // R9

endmodule

// File: tb/tb_pgwalk_top.sv
`timescale 1ns/1ps
module tb_pgwalk_top;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic [1:0]  nwr;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0123, 1'b0, 1'b1, 2'b00, 32'h0000_5123, 2'd2}, // R1 R5 basic read
        '{32'h0000_0ABC, 1'b1, 1'b1, 2'b00, 32'h0000_5ABC, 2'd2}, // R6 write
        '{32'h0040_1010, 1'b0, 1'b1, 2'b00, 32'h0000_5010, 2'd2}, // R1 second table
        '{32'h0040_1010, 1'b1, 1'b1, 2'b10, 32'h0000_0000, 2'd0}, // R3 dir read-only
        '{32'h0080_0FFF, 1'b0, 1'b0, 2'b00, 32'h0000_5FFF, 2'd2}, // R10 alias dir
        '{32'h0100_0000, 1'b0, 1'b0, 2'b01, 32'h0000_0000, 2'd0}, // R2 dir absent
        '{32'h0000_3004, 1'b0, 1'b0, 2'b01, 32'h0000_0000, 2'd0}, // R2 table absent
        '{32'h0000_2008, 1'b0, 1'b1, 2'b11, 32'h0000_0000, 2'd0}, // R4 table supervisor-only
        '{32'h0000_2008, 1'b1, 1'b0, 2'b00, 32'h0000_7008, 2'd2}, // R4 supervisor ignores
        '{32'h00C0_1000, 1'b0, 1'b1, 2'b11, 32'h0000_0000, 2'd0}, // R4 dir supervisor-only
        '{32'h00C0_1000, 1'b1, 1'b0, 2'b00, 32'h0000_5000, 2'd2}, // R4 supervisor via dir
        '{32'h0000_1004, 1'b1, 1'b1, 2'b10, 32'h0000_0000, 2'd0}, // R3 table read-only
        '{32'h0000_1004, 1'b1, 1'b0, 2'b10, 32'h0000_0000, 2'd0}, // R3 supervisor too
        '{32'h0000_4321, 1'b1, 1'b1, 2'b00, 32'h0000_8321, 2'd1}  // R5 flags already set
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] root_base = 32'h0000_1000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [0:4095];
    int          lat = 0;
    int          wait_cnt = 0;
    logic        clr = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [0:3];
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    int          stab_err = 0;

    logic        got_fault;
    logic [1:0]  got_cause;
    logic [31:0] got_paddr;
    logic        got_ok;

    always #4 clk = ~clk;

    pgwalk_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vaddr (req_vaddr),
        .req_write (req_write),
        .req_user  (req_user),
        .root_base (root_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

    // Memory model with programmable latency; logs accesses
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (prev_pend && (!mem_req || mem_addr != prev_addr)) stab_err <= stab_err + 1;
        prev_pend <= mem_req && !mem_ack;
        prev_addr <= mem_addr;
        if (clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[32'h1000 >> 2] = 32'h0000_2007; // dir 0 -> table A, P W U
        mem[32'h1004 >> 2] = 32'h0000_3005; // dir 1 -> table B, P U
        mem[32'h1008 >> 2] = 32'h0000_2007; // dir 2 -> table A (alias)
        mem[32'h100C >> 2] = 32'h0000_3003; // dir 3 -> table B, P W
        mem[32'h2000 >> 2] = 32'h0000_5007; // A[0] frame 5 P W U
        mem[32'h2004 >> 2] = 32'h0000_6005; // A[1] frame 6 P U
        mem[32'h2008 >> 2] = 32'h0000_7003; // A[2] frame 7 P W
        mem[32'h2010 >> 2] = 32'h0000_8067; // A[4] frame 8 P W U A D
        mem[32'h3004 >> 2] = 32'h0000_5007; // B[1] frame 5 P W U
    endtask

    task automatic walk(input logic [31:0] va, input logic wr, input logic usr);
        got_ok = 1'b0;
        @(negedge clk);
        clr       = 1'b1;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_user  = usr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        clr       = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (rsp_valid) begin
                got_ok    = 1'b1;
                got_fault = rsp_fault;
                got_cause = rsp_cause;
                got_paddr = rsp_paddr;
                break;
            end
            @(negedge clk);
        end
        if (!got_ok) begin
            tests++;
            fails++;
            $display("FAIL R9 no response actual=0 expected=1");
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 ready after reset", 32'(req_ready), 32'd1);
        check("R9 no rsp after reset", 32'(rsp_valid), 32'd0);
        check("R8 no mem_req after reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: fresh image each walk
        for (int v = 0; v < NVEC; v++) begin
            init_mem();
            walk(VECS[v].va, VECS[v].wr, VECS[v].usr);
            check($sformatf("R2/R3/R4 cause v%0d", v), 32'(got_cause), 32'(VECS[v].cause));
            check($sformatf("R9 fault flag v%0d", v), 32'(got_fault), 32'(VECS[v].cause != 2'b00));
            check($sformatf("R1 paddr v%0d", v), got_paddr, VECS[v].pa);
            check($sformatf("R5/R7 write count v%0d", v), 32'(wr_cnt), 32'(VECS[v].nwr));
        end

        // R5 R6: read sets only accessed; write then sets only dirty in table
        init_mem();
        walk(32'h0000_0123, 1'b0, 1'b1);
        check("R5 dir accessed", word_at(32'h1000), 32'h0000_2027);
        check("R6 read leaves dirty clear", word_at(32'h2000), 32'h0000_5027);
        walk(32'h0000_0123, 1'b0, 1'b1);
        check("R5 no rewrite when set", 32'(wr_cnt), 32'd0);
        walk(32'h0000_0123, 1'b1, 1'b1);
        check("R6 one write for dirty", 32'(wr_cnt), 32'd1);
        check("R6 table dirty set", word_at(32'h2000), 32'h0000_5067);
        check("R6 dir dirty untouched", word_at(32'h1000), 32'h0000_2027);

        // R1 read addresses
        init_mem();
        walk(32'h0040_1010, 1'b0, 1'b1);
        check("R1 dir read addr", rd_log[0], 32'h0000_1004);
        check("R1 table read addr", rd_log[1], 32'h0000_3004);

        // R2 walk stops at absent directory entry; R7 memory untouched
        init_mem();
        walk(32'h0100_0000, 1'b1, 1'b1);
        check("R2 single read", 32'(rd_cnt), 32'd1);
        init_mem();
        walk(32'h0000_1004, 1'b1, 1'b1);
        check("R7 dir unchanged after fault", word_at(32'h1000), 32'h0000_2007);

        // R10 aliasing
        init_mem();
        walk(32'h0080_0FFF, 1'b1, 1'b0);
        check("R10 alias paddr", got_paddr, 32'h0000_5FFF);
        check("R10 used dir accessed", word_at(32'h1008), 32'h0000_2027);
        check("R10 other dir untouched", word_at(32'h1000), 32'h0000_2007);
        check("R10 shared table flags", word_at(32'h2000), 32'h0000_5067);

        // R8 slow memory
        lat = 3;
        init_mem();
        walk(32'h0000_0ABC, 1'b1, 1'b1);
        check("R8 paddr with latency", got_paddr, 32'h0000_5ABC);
        check("R8 writes with latency", 32'(wr_cnt), 32'd2);
        check("R8 request stability", 32'(stab_err), 32'd0);
        lat = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule